// File: doc/BRIEF.md
# Memory Protection Region Checker

The checker sits next to a processor's bus and rules on every access the core makes: a load, a store or an instruction fetch. It holds a fixed number of programmable region slots. Each slot has a base address, a size that is a power of two, a permission code and an execute-never flag. For each access the checker combinationally reports whether it faults and which region decided. The first fault is recorded in a sticky log that holds the address and the kind of access. Software clears the log with a command write.

Software programs the slots and a small control word through a single write port. The port selects a target with a 2-bit selector and a slot index. Each configuration write takes effect from the next clock cycle. When regions overlap, the highest-numbered one wins. An access that hits no region is allowed only for privileged code, and only while the background map is switched on.

Top module: `prot_checker`

## Requirements
- R1: After reset every slot is disabled, the checker is off and the fault log is empty. While the checker is off (control bit 0 clear), every access reports acc_fault=0 and hit_valid=0.
- R2: An enabled slot with size field s in 4..31 covers 2^(s+1) bytes. It matches an address when the address bits above bit s equal the same bits of the base, so the base bits below s+1 are ignored. s=31 covers the whole 4 GB space.
- R3: A slot whose size field is below 4 never matches, even when its enable bit is set.
- R4: When several enabled slots match, the highest-numbered one is reported on hit_idx (with hit_valid=1) and alone decides the permission.
- R5: Permission code (attribute bits 10:8). 0 gives no access. 1 gives privileged read-write only. 2 gives privileged read-write and unprivileged read-only. 3 gives read-write at both levels. 5 gives privileged read-only only. 6 gives read-only at both levels. 4 and 7 give no access. A store into a read-only slot faults. A store one byte past the slot's end is not decided by that slot.
- R6: When the execute-never flag (attribute bit 12) is set, every fetch (acc_type 2) from the slot faults. Without the flag, a fetch needs read permission. Reads use acc_type 0 and writes acc_type 1. acc_type 3 is treated as a read.
- R7: With the checker on, an access that matches no slot is allowed only if acc_priv=1 and the background bit (control bit 1) is set. Otherwise it faults.
- R8: A fault while the log is empty sets flt_valid in the next cycle, with flt_addr equal to the access address and flt_type equal to the access kind code. Later faults leave the logged values unchanged.
- R9: A configuration write with cfg_sel=3 empties the log in the next cycle. If a fault occurs in the same cycle as the clear, that fault is logged instead.
- R10: cfg_sel=0 writes the slot base. cfg_sel=1 writes the slot attributes: bit 0 enable, bits 5:1 size, bits 10:8 permission, bit 12 execute-never. cfg_sel=2 writes the control word. An access in the same cycle as a write is judged with the old settings.
- R11: While acc_valid=0 the checker reports acc_fault=0 and hit_valid=0, and it logs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 base, 1 attributes, 2 control, 3 clear log |
| cfg_idx | input | IDX_W | Slot index for base and attribute writes |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_priv | input | 1 | 1 for privileged access |
| acc_fault | output | 1 | Access is denied (combinational) |
| hit_valid | output | 1 | An enabled slot matched |
| hit_idx | output | IDX_W | Deciding slot index |
| flt_valid | output | 1 | Fault log holds an entry |
| flt_addr | output | ADDR_W | Logged fault address |
| flt_type | output | 2 | Logged access kind |

## Verification
The bench aims at the edges of the regions. It stores to the first and the last byte of a small read-only slot and one byte past its end. A comparator that is off by one would either flag the neighbour or let the last byte through. A slot is given an unaligned base, so a design that compares the low base bits would miss the hits inside that slot. Other tests cover size fields 3 and 31, overlapping slots (a wrong priority would report the lower index), fetches from an execute-never slot, and the no-hit rule at each privilege level. The log is tested against overwriting, against a clear in the same cycle as a new fault, and against a write and an access in the same cycle, which a design that bypasses its registers would judge with the new settings.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_BG_BIT   = 1;
    localparam int ATTR_EN_BIT  = 0;
    localparam int ATTR_SZ_LO   = 1;
    localparam int ATTR_PERM_LO = 8;
    localparam int ATTR_XN_BIT  = 12;
    localparam int ATTR_W       = 13;
    localparam int MIN_SIZE_FLD = 4;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_FX = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_ATTR = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_CLR  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic       xn;
        logic [2:0] perm;
        logic [4:0] size;
        logic       en;
    } region_attr_t;

    typedef struct packed {
        logic priv_rd;
        logic priv_wr;
        logic user_rd;
        logic user_wr;
    } rights_t;

    function automatic region_attr_t unpack_attr(input logic [ATTR_W-1:0] w);
        region_attr_t a;
        a.en   = w[ATTR_EN_BIT];
        a.size = w[ATTR_SZ_LO +: 5];
        a.perm = w[ATTR_PERM_LO +: 3];
        a.xn   = w[ATTR_XN_BIT];
        return a;
    endfunction

    function automatic rights_t decode_perm(input logic [2:0] code);
        rights_t r;
        case (code)
            3'd1:    r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b0, user_wr: 1'b0};
            3'd2:    r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b0};
            3'd3:    r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b1};
            3'd5:    r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b0, user_wr: 1'b0};
            3'd6:    r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b1, user_wr: 1'b0};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic access_ok(input rights_t r, input logic xn,
                                       input acc_kind_e k, input logic priv);
        logic rd, wr;
        rd = priv ? r.priv_rd : r.user_rd;
        wr = priv ? r.priv_wr : r.user_wr;
        case (k)
            ACC_WR:  return wr;
            ACC_FX:  return rd && !xn;
            default: return rd;
        endcase
    endfunction

    function automatic acc_kind_e to_kind(input logic [1:0] t);
        case (t)
            2'd1:    return ACC_WR;
            2'd2:    return ACC_FX;
            default: return ACC_RD;
        endcase
    endfunction

endpackage

// File: rtl/pc_region_slot.sv
module pc_region_slot
    import pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_base,
    input  logic                  wr_attr,
    input  logic [ADDR_W-1:0]     base_in,
    input  logic [ATTR_W-1:0]     attr_in,
    input  logic [ADDR_W-1:0]     addr,
    input  acc_kind_e             kind,
    input  logic                  priv,
    output logic                  match,
    output logic                  permit
);

    localparam int SHW = $clog2(ADDR_W + 1) + 1;

    logic [ADDR_W-1:0] base_q;
    region_attr_t      attr_q;
    logic [SHW-1:0]    shamt;
    logic [ADDR_W-1:0] upper_diff;
    logic              size_legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            attr_q <= '0;
        end else begin
            if (wr_base) base_q <= base_in;
            if (wr_attr) attr_q <= unpack_attr(attr_in);
        end
    end

    always_comb begin
        size_legal = (attr_q.size >= 5'(MIN_SIZE_FLD));
        shamt      = SHW'(attr_q.size) + SHW'(1);
        upper_diff = (addr ^ base_q) >> shamt;
        match      = attr_q.en && size_legal && (upper_diff == '0);
        permit     = access_ok(decode_perm(attr_q.perm), attr_q.xn, kind, priv);
    end

endmodule

// File: rtl/pc_priority_pick.sv
module pc_priority_pick #(
    parameter int NUM_REGIONS = 4,
    parameter int IDX_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_REGIONS-1:0] match_vec,
    input  logic [NUM_REGIONS-1:0] permit_vec,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx,
    output logic                   win_permit
);

    always_comb begin
        any_hit    = 1'b0;
        win_idx    = '0;
        win_permit = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match_vec[i]) begin
                any_hit    = 1'b1;
                win_idx    = IDX_W'(i);
                win_permit = permit_vec[i];
            end
        end
    end

    // R4
    winner_matches_chk: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> match_vec[win_idx]);

    // R4
    no_higher_match_chk: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ((match_vec >> win_idx) == {{(NUM_REGIONS-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/pc_fault_log.sv
module pc_fault_log
    import pc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fault,
    input  logic [ADDR_W-1:0] addr,
    input  acc_kind_e         kind,
    output logic              log_valid,
    output logic [ADDR_W-1:0] log_addr,
    output logic [1:0]        log_type
);

    logic capture;

    always_comb capture = fault && (!log_valid || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            log_valid <= 1'b0;
            log_addr  <= '0;
            log_type  <= 2'd0;
        end else if (capture) begin
            log_valid <= 1'b1;
            log_addr  <= addr;
            log_type  <= kind;
        end else if (clr) begin
            log_valid <= 1'b0;
        end
    end

    // R8
    fault_logged_chk: assert property (@(posedge clk) disable iff (rst)
        fault && (!log_valid || clr) |=> log_valid && log_addr == $past(addr)
                                         && log_type == $past(kind));

    // R8
    log_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        log_valid && !clr |=> log_valid && $stable(log_addr) && $stable(log_type));

    // R9
    log_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !fault |=> !log_valid);

endmodule

// File: rtl/prot_checker.sv
module prot_checker
    import pc_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_priv,
    output logic              acc_fault,
    output logic              hit_valid,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [1:0]        flt_type
);

    logic                   ctl_en;
    logic                   ctl_bg;
    acc_kind_e              kind;
    logic [NUM_REGIONS-1:0] match_vec;
    logic [NUM_REGIONS-1:0] permit_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic                   win_permit;
    logic                   log_clr;
    logic                   active;

    always_comb kind = to_kind(acc_type);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en <= 1'b0;
            ctl_bg <= 1'b0;
        end else if (cfg_we && cfg_sel == SEL_CTL) begin
            ctl_en <= cfg_wdata[CTL_EN_BIT];
            ctl_bg <= cfg_wdata[CTL_BG_BIT];
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
        logic sel_here;
        always_comb sel_here = cfg_we && (cfg_idx == IDX_W'(g));
        pc_region_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_base (sel_here && cfg_sel == SEL_BASE),
            .wr_attr (sel_here && cfg_sel == SEL_ATTR),
            .base_in (cfg_wdata),
            .attr_in (cfg_wdata[ATTR_W-1:0]),
            .addr    (acc_addr),
            .kind    (kind),
            .priv    (acc_priv),
            .match   (match_vec[g]),
            .permit  (permit_vec[g])
        );
    end

    pc_priority_pick #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .match_vec  (match_vec),
        .permit_vec (permit_vec),
        .any_hit    (any_hit),
        .win_idx    (win_idx),
        .win_permit (win_permit)
    );

    always_comb begin
        active    = acc_valid && ctl_en;
        hit_valid = active && any_hit;
        hit_idx   = any_hit ? win_idx : '0;
        if (!active)
            acc_fault = 1'b0;
        else if (any_hit)
            acc_fault = !win_permit;
        else
            acc_fault = !(acc_priv && ctl_bg);
        log_clr = cfg_we && cfg_sel == SEL_CLR;
    end

    pc_fault_log #(.ADDR_W(ADDR_W)) u_log (
        .clk       (clk),
        .rst       (rst),
        .clr       (log_clr),
        .fault     (acc_fault),
        .addr      (acc_addr),
        .kind      (kind),
        .log_valid (flt_valid),
        .log_addr  (flt_addr),
        .log_type  (flt_type)
    );

    // R7
    user_miss_faults_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && ctl_en && !acc_priv && !any_hit |-> acc_fault);

    // R1
    off_allows_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> !acc_fault && !hit_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc_fault && !hit_valid);

endmodule

// File: tb/tb_prot_checker.sv
module tb_prot_checker;

    localparam int NR = 4;
    localparam int AW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_type = 2'd0;
    logic          acc_priv = 1'b0;
    logic          acc_fault, hit_valid, flt_valid;
    logic [IW-1:0] hit_idx;
    logic [AW-1:0] flt_addr;
    logic [1:0]    flt_type;

    int total = 0;
    int bad   = 0;

    prot_checker #(.NUM_REGIONS(NR), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_priv(acc_priv), .acc_fault(acc_fault),
        .hit_valid(hit_valid), .hit_idx(hit_idx), .flt_valid(flt_valid),
        .flt_addr(flt_addr), .flt_type(flt_type)
    );

    always #4 clk = ~clk;

    // bench model
    logic [31:0] m_base [NR];
    logic [31:0] m_attr [NR];
    logic        m_en, m_bg;
    logic        m_fv;
    logic [31:0] m_fa;
    logic [1:0]  m_ft;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_rights(input logic [2:0] p, input bit pv, input bit wr);
        bit pr, pw, ur, uw;
        {pr, pw, ur, uw} = 4'b0000;
        case (p)
            3'd1: {pr, pw, ur, uw} = 4'b1100;
            3'd2: {pr, pw, ur, uw} = 4'b1110;
            3'd3: {pr, pw, ur, uw} = 4'b1111;
            3'd5: {pr, pw, ur, uw} = 4'b1000;
            3'd6: {pr, pw, ur, uw} = 4'b1010;
            default: ;
        endcase
        if (wr) return pv ? pw : uw;
        return pv ? pr : ur;
    endfunction

    function automatic bit m_inside(input int r, input logic [31:0] a);
        logic [32:0] sz, lo;
        int s;
        s = int'(m_attr[r][5:1]);
        if (!m_attr[r][0] || s < 4) return 0;
        sz = 33'd1 << (s + 1);
        lo = {1'b0, m_base[r]} & ~(sz - 33'd1);
        return ({1'b0, a} >= lo) && ({1'b0, a} < lo + sz);
    endfunction

    task automatic m_eval(input logic av, input logic [31:0] a, input logic [1:0] t,
                          input logic pv, output bit f, output bit hv, output int idx);
        bit ok;
        f = 0; hv = 0; idx = 0;
        if (!av || !m_en) return;
        for (int r = 0; r < NR; r++) if (m_inside(r, a)) begin hv = 1; idx = r; end
        if (hv) begin
            if (t == 2'd2)
                ok = !m_attr[idx][12] && m_rights(m_attr[idx][10:8], pv, 0);
            else
                ok = m_rights(m_attr[idx][10:8], pv, t == 2'd1);
            f = !ok;
        end else begin
            f = !(pv && m_bg);
        end
    endtask

    task automatic cyc(input bit we, input logic [1:0] sel, input int idx,
                       input logic [31:0] wd, input bit av, input logic [31:0] a,
                       input logic [1:0] t, input bit pv, input string tag);
        bit f, hv;
        int ei;
        @(negedge clk);
        chk(flt_valid === m_fv, "R8 flt_valid", 32'(flt_valid), 32'(m_fv));
        if (m_fv) begin
            chk(flt_addr === m_fa, "R8 flt_addr", flt_addr, m_fa);
            chk(flt_type === m_ft, "R8 flt_type", 32'(flt_type), 32'(m_ft));
        end
        cfg_we = we; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = wd;
        acc_valid = av; acc_addr = a; acc_type = t; acc_priv = pv;
        #2;
        m_eval(av, a, t, pv, f, hv, ei);
        chk(acc_fault === f, {tag, " acc_fault"}, 32'(acc_fault), 32'(f));
        chk(hit_valid === hv, {tag, " hit_valid"}, 32'(hit_valid), 32'(hv));
        if (hv) chk(hit_idx === IW'(ei), {tag, " hit_idx"}, 32'(hit_idx), 32'(ei));
        if (f && (!m_fv || (we && sel == 2'd3))) begin
            m_fv = 1; m_fa = a; m_ft = (t == 2'd3) ? 2'd0 : t;
        end else if (we && sel == 2'd3) begin
            m_fv = 0;
        end
        if (we) begin
            case (sel)
                2'd0: m_base[idx] = wd;
                2'd1: m_attr[idx] = wd;
                2'd2: begin m_en = wd[0]; m_bg = wd[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int idx, input logic [31:0] wd,
                      input string tag);
        cyc(1, sel, idx, wd, 0, 32'h0, 2'd0, 0, tag);
    endtask

    task automatic ac(input logic [31:0] a, input logic [1:0] t, input bit pv,
                      input string tag);
        cyc(0, 2'd0, 0, 32'h0, 1, a, t, pv, tag);
    endtask

    function automatic logic [31:0] attr(input bit en, input int sz, input int p, input bit xn);
        return 32'(en) | (32'(sz) << 1) | (32'(p) << 8) | (32'(xn) << 12);
    endfunction

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        for (int r = 0; r < NR; r++) begin m_base[r] = 0; m_attr[r] = 0; end
        m_en = 0; m_bg = 0; m_fv = 0; m_fa = 0; m_ft = 0;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, checker off
        ac(32'h2000_E000, 2'd1, 0, "R1");
        ac(32'h0000_0000, 2'd2, 0, "R1");

        // R10: program slot 0 as a 128-byte read-only execute-never guard
        wr(2'd0, 0, 32'h2000_E000, "R10");
        wr(2'd1, 0, attr(1, 6, 6, 1), "R10");
        wr(2'd2, 0, 32'h3, "R10");
        // R5: store into the guard faults, first and last byte
        ac(32'h2000_E000, 2'd1, 1, "R5");
        ac(32'h2000_E07F, 2'd1, 1, "R5");
        // R5: one byte past the end is not decided by the guard
        ac(32'h2000_E080, 2'd1, 1, "R5");
        ac(32'h2000_E010, 2'd0, 0, "R5");
        // R6: fetch from execute-never slot faults
        ac(32'h2000_E004, 2'd2, 1, "R6");
        // R9: clear the log
        wr(2'd3, 0, 32'h0, "R9");
        ac(32'h2000_E004, 2'd2, 1, "R6");
        // R9: clear and fault in the same cycle, new fault logged
        cyc(1, 2'd3, 0, 32'h0, 1, 32'h2000_E020, 2'd1, 0, "R9");
        wr(2'd3, 0, 32'h0, "R9");

        // R3: size field 3 never matches
        wr(2'd0, 1, 32'h2000_E000, "R3");
        wr(2'd1, 1, attr(1, 3, 3, 0), "R3");
        ac(32'h2000_E000, 2'd0, 1, "R3");
        wr(2'd0, 1, 32'h3000_0000, "R3");
        ac(32'h3000_0004, 2'd0, 1, "R3");

        // R4: overlapping slot 2 wins over slot 0
        wr(2'd0, 2, 32'h2000_E000, "R4");
        wr(2'd1, 2, attr(1, 10, 3, 0), "R4");
        ac(32'h2000_E000, 2'd1, 0, "R4");
        ac(32'h2000_E400, 2'd2, 0, "R4");

        // R2: unaligned base, low bits ignored
        wr(2'd0, 3, 32'h4000_0123, "R2");
        wr(2'd1, 3, attr(1, 7, 2, 0), "R2");
        ac(32'h4000_0100, 2'd1, 0, "R2");
        ac(32'h4000_01FF, 2'd0, 0, "R2");
        ac(32'h4000_00FF, 2'd0, 1, "R2");
        ac(32'h4000_0200, 2'd0, 1, "R2");
        // R2: size 31 covers everything
        wr(2'd1, 3, attr(1, 31, 5, 0), "R2");
        ac(32'hFFFF_FFFC, 2'd0, 1, "R2");
        ac(32'h0000_0000, 2'd1, 1, "R2");
        wr(2'd1, 3, 32'h0, "R2");

        // R7: no-hit rule
        wr(2'd3, 0, 32'h0, "R9");
        ac(32'h5000_0000, 2'd0, 0, "R7");
        wr(2'd2, 0, 32'h1, "R7");
        ac(32'h5000_0000, 2'd0, 1, "R7");
        wr(2'd2, 0, 32'h3, "R7");
        ac(32'h5000_0000, 2'd3, 1, "R7");

        // R11: idle cycle with a faulting address logs nothing
        wr(2'd3, 0, 32'h0, "R9");
        cyc(0, 2'd0, 0, 32'h0, 0, 32'h2000_E000, 2'd1, 0, "R11");
        ac(32'h6000_0000, 2'd0, 1, "R11");

        // R10: write and access in same cycle use old settings
        cyc(1, 2'd1, 2, 32'h0, 1, 32'h2000_E000, 2'd1, 0, "R10");
        ac(32'h2000_E000, 2'd1, 0, "R10");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int unsigned pick = $urandom_range(0, 99);
            int r = int'($urandom_range(0, NR - 1));
            logic [31:0] pool = 32'h2000_0000 + ($urandom_range(0, 7) << 10);
            if (pick < 6) begin
                wr(2'd0, r, pool + $urandom_range(0, 255), "R2");
            end else if (pick < 12) begin
                int sz = (pick == 11) ? 31 : int'($urandom_range(2, 12));
                wr(2'd1, r, attr($urandom_range(0, 3) != 0, sz,
                                 int'($urandom_range(0, 7)), $urandom_range(0, 1) == 1), "R5");
            end else if (pick < 14) begin
                wr(2'd2, 0, 32'($urandom_range(0, 3)), "R10");
            end else if (pick < 16) begin
                wr(2'd3, 0, 32'h0, "R9");
            end else begin
                cyc(0, 2'd0, 0, 32'h0, $urandom_range(0, 9) != 0,
                    pool + $urandom_range(0, 2047), 2'($urandom_range(0, 3)),
                    $urandom_range(0, 1) == 1, "R4");
            end
        end
        cyc(0, 2'd0, 0, 32'h0, 0, 32'h0, 2'd0, 0, "R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule